// File: doc/BRIEF.md
# Adaptive Transmit Start Threshold Controller

This block decides when a network transmitter may begin sending a frame whose bytes are still arriving in the transmit FIFO from the host bus. It holds a 3-bit commit level. Each code from 0 to 4 selects a start threshold of 64 bytes doubled once per step. Codes 5 to 7 require the whole frame to be in the FIFO before sending. Starting early keeps latency low. If a frame is aborted because the FIFO ran dry, the level climbs by one step, so the threshold follows the latency the host bus actually shows.

Large thresholds can deadlock. The transmitter waits for more data, while the DMA engine waits for FIFO space before it starts its next bus transfer. From level 3 upward the block detects this and grants the start early. Software may set the level only while the adapter is held in its soft reset. The grant is evaluated once per frame and held until the frame ends or is aborted.

Top module: `tx_start_ctrl`

## Requirements
- R1: After rst_ni is asserted, level_o is 0 and tx_start_o is 0.
- R2: At level codes 0 to 4, tx_start_o rises one clock after fifo_bytes_i is at least 64 << level_o. One byte fewer does not grant.
- R3: At level codes 5, 6 and 7, tx_start_o rises one clock after frame_loaded_i is 1, whatever the byte count. With frame_loaded_i at 0 and no deadlock, no grant is given.
- R4: At level 3 or higher, tx_wait_i and dma_stall_i both high grant tx_start_o one clock later, below threshold. At levels 0 to 2 that condition alone grants nothing.
- R5: An underrun_abort_i pulse raises level_o by one, visible one clock later.
- R6: level_o saturates at 7. An underrun at level 7 leaves it at 7.
- R7: A write through lvl_we_i and lvl_wdata_i takes effect one clock later only while adapter_rst_i is 1. At other times the write leaves level_o unchanged.
- R8: When a permitted write and an underrun_abort_i fall in the same cycle, level_o takes the written value.
- R9: Once granted, tx_start_o stays 1 even if the FIFO drains. frame_end_i or underrun_abort_i clears it one clock later, and a clear wins over a new grant in the same cycle.
- R10: tx_start_o is 0 from the clock after adapter_rst_i is 1, for as long as it stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| adapter_rst_i | input | 1 | Adapter soft reset held; enables level writes, blocks grant |
| lvl_we_i | input | 1 | Level write strobe |
| lvl_wdata_i | input | 3 | Level value to write |
| fifo_bytes_i | input | CNT_W (12) | Bytes currently in the transmit FIFO |
| frame_loaded_i | input | 1 | Whole current frame is in the FIFO |
| tx_wait_i | input | 1 | Transmitter waiting for threshold data |
| dma_stall_i | input | 1 | Next bus transfer waiting for FIFO space |
| underrun_abort_i | input | 1 | Frame aborted by FIFO underrun (pulse) |
| frame_end_i | input | 1 | Current frame finished (pulse) |
| tx_start_o | output | 1 | Transmit start grant, latched per frame |
| level_o | output | 3 | Current commit level |

## Verification
The bench builds the block with its default parameters. The 12-bit byte count holds the full 1024-byte threshold of level 4, and the 64-byte base makes each step's exact boundary reachable one byte below and at the threshold. The deadlock rule starts at level 3 and the sized range ends at level 4. With these defaults the bench reaches every transition between sized, deadlock-capable and whole-frame codes, as well as saturation at 7.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_MAX = lvl_t'((1 << LVL_W) - 1);
endpackage

// File: rtl/tsc_level_reg.sv
module tsc_level_reg
  import tsc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  lvl_t wr_data_i,
  input  logic bump_i,
  output lvl_t level_o
);
  lvl_t level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           level_q <= '0;
    else if (wr_en_i)                      level_q <= wr_data_i;
    else if (bump_i && level_q != LVL_MAX) level_q <= level_q + lvl_t'(1);
  end

  assign level_o = level_q;
endmodule

// File: rtl/tsc_start_eval.sv
module tsc_start_eval
  import tsc_pkg::*;
#(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned BASE_LOG2 = 6,
  parameter int unsigned SIZED_MAX = 4,
  parameter int unsigned DLK_MIN   = 3
) (
  input  lvl_t             level_i,
  input  logic [CNT_W-1:0] fifo_bytes_i,
  input  logic             frame_loaded_i,
  input  logic             tx_wait_i,
  input  logic             dma_stall_i,
  output logic             start_ok_o
);
  localparam int unsigned NUM_LVL = 1 << LVL_W;

  logic [NUM_LVL-1:0] lvl_ok;
  logic               dlk_hit;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    if (g <= SIZED_MAX) begin : g_sized
      localparam logic [CNT_W:0] THR = (CNT_W+1)'(1) << (BASE_LOG2 + g);
      assign lvl_ok[g] = {1'b0, fifo_bytes_i} >= THR;
    end else begin : g_whole
      assign lvl_ok[g] = frame_loaded_i;
    end
  end

  // transmitter starved while DMA blocked on space: break it at large levels
  assign dlk_hit    = (int'(level_i) >= DLK_MIN) && tx_wait_i && dma_stall_i;
  assign start_ok_o = lvl_ok[level_i] || dlk_hit;
endmodule

// File: rtl/tsc_grant_latch.sv
module tsc_grant_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_off_i,
  input  logic clear_i,
  input  logic set_i,
  output logic grant_o
);
  logic grant_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    grant_q <= 1'b0;
    else if (hold_off_i || clear_i) grant_q <= 1'b0;
    else if (set_i)                 grant_q <= 1'b1;
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/tx_start_ctrl.sv
module tx_start_ctrl
  import tsc_pkg::*;
#(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned BASE_LOG2 = 6,
  parameter int unsigned SIZED_MAX = 4,
  parameter int unsigned DLK_MIN   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adapter_rst_i,
  input  logic             lvl_we_i,
  input  logic [2:0]       lvl_wdata_i,
  input  logic [CNT_W-1:0] fifo_bytes_i,
  input  logic             frame_loaded_i,
  input  logic             tx_wait_i,
  input  logic             dma_stall_i,
  input  logic             underrun_abort_i,
  input  logic             frame_end_i,
  output logic             tx_start_o,
  output logic [2:0]       level_o
);
  lvl_t level;
  logic wr_ok;
  logic start_ok;

  assign wr_ok = adapter_rst_i && lvl_we_i;

  tsc_level_reg u_level (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_ok),
    .wr_data_i (lvl_wdata_i),
    .bump_i    (underrun_abort_i),
    .level_o   (level)
  );

  tsc_start_eval #(
    .CNT_W     (CNT_W),
    .BASE_LOG2 (BASE_LOG2),
    .SIZED_MAX (SIZED_MAX),
    .DLK_MIN   (DLK_MIN)
  ) u_eval (
    .level_i        (level),
    .fifo_bytes_i   (fifo_bytes_i),
    .frame_loaded_i (frame_loaded_i),
    .tx_wait_i      (tx_wait_i),
    .dma_stall_i    (dma_stall_i),
    .start_ok_o     (start_ok)
  );

  tsc_grant_latch u_grant (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_off_i (adapter_rst_i),
    .clear_i    (frame_end_i || underrun_abort_i),
    .set_i      (start_ok),
    .grant_o    (tx_start_o)
  );

  assign level_o = level;
endmodule

// File: rtl/tx_start_ctrl_chk.sv
module tx_start_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       adapter_rst_i,
  input logic       lvl_we_i,
  input logic [2:0] lvl_wdata_i,
  input logic       tx_wait_i,
  input logic       dma_stall_i,
  input logic       underrun_abort_i,
  input logic       frame_end_i,
  input logic       tx_start_o,
  input logic [2:0] level_o
);
  AST_LVL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(adapter_rst_i && lvl_we_i) && underrun_abort_i && level_o != 3'd7)
    |=> level_o == 3'($past(level_o) + 3'd1)); // R5

  AST_LVL_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == 3'd7 && !(adapter_rst_i && lvl_we_i)) |=> level_o == 3'd7); // R6

  AST_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adapter_rst_i && !underrun_abort_i) |=> $stable(level_o)); // R7

  AST_WR_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adapter_rst_i && lvl_we_i) |=> level_o == $past(lvl_wdata_i)); // R8

  AST_GRANT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i || underrun_abort_i) |=> !tx_start_o); // R9

  AST_GRANT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start_o && !frame_end_i && !underrun_abort_i && !adapter_rst_i) |=> tx_start_o); // R9

  AST_RST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adapter_rst_i |=> !tx_start_o); // R10

  AST_DLK_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o >= 3'd3 && tx_wait_i && dma_stall_i && !adapter_rst_i &&
     !frame_end_i && !underrun_abort_i) |=> tx_start_o); // R4
endmodule

bind tx_start_ctrl tx_start_ctrl_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .adapter_rst_i    (adapter_rst_i),
  .lvl_we_i         (lvl_we_i),
  .lvl_wdata_i      (lvl_wdata_i),
  .tx_wait_i        (tx_wait_i),
  .dma_stall_i      (dma_stall_i),
  .underrun_abort_i (underrun_abort_i),
  .frame_end_i      (frame_end_i),
  .tx_start_o       (tx_start_o),
  .level_o          (level_o)
);

// File: tb/tx_start_ctrl_tb.sv
module tx_start_ctrl_tb;
  localparam int CNT_W = 12;
  localparam int NV    = 19;
  // {level, bytes, loaded, wait, stall, expected grant}
  localparam logic [18:0] VEC [NV] = '{
    {3'd0, 12'd63,   1'b0, 1'b0, 1'b0, 1'b0},
    {3'd0, 12'd64,   1'b0, 1'b0, 1'b0, 1'b1},
    {3'd1, 12'd127,  1'b0, 1'b0, 1'b0, 1'b0},
    {3'd1, 12'd128,  1'b0, 1'b0, 1'b0, 1'b1},
    {3'd2, 12'd255,  1'b0, 1'b0, 1'b0, 1'b0},
    {3'd2, 12'd256,  1'b0, 1'b0, 1'b0, 1'b1},
    {3'd2, 12'd100,  1'b0, 1'b1, 1'b1, 1'b0},
    {3'd3, 12'd511,  1'b0, 1'b0, 1'b0, 1'b0},
    {3'd3, 12'd512,  1'b0, 1'b0, 1'b0, 1'b1},
    {3'd3, 12'd100,  1'b0, 1'b1, 1'b1, 1'b1},
    {3'd3, 12'd100,  1'b0, 1'b1, 1'b0, 1'b0},
    {3'd4, 12'd1023, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd4, 12'd1024, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd5, 12'd4000, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd5, 12'd4000, 1'b1, 1'b0, 1'b0, 1'b1},
    {3'd5, 12'd10,   1'b0, 1'b1, 1'b1, 1'b1},
    {3'd6, 12'd2048, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd7, 12'd5,    1'b1, 1'b0, 1'b0, 1'b1},
    {3'd7, 12'd0,    1'b0, 1'b1, 1'b1, 1'b1}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             adapter_rst_i = 1'b0;
  logic             lvl_we_i = 1'b0;
  logic [2:0]       lvl_wdata_i = '0;
  logic [CNT_W-1:0] fifo_bytes_i = '0;
  logic             frame_loaded_i = 1'b0;
  logic             tx_wait_i = 1'b0;
  logic             dma_stall_i = 1'b0;
  logic             underrun_abort_i = 1'b0;
  logic             frame_end_i = 1'b0;
  logic             tx_start_o;
  logic [2:0]       level_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  tx_start_ctrl u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    fifo_bytes_i = '0; frame_loaded_i = 0; tx_wait_i = 0; dma_stall_i = 0;
    underrun_abort_i = 0; frame_end_i = 0; lvl_we_i = 0; adapter_rst_i = 0;
  endtask

  task automatic set_level(input logic [2:0] v);
    @(negedge clk_i); adapter_rst_i = 1; lvl_we_i = 1; lvl_wdata_i = v;
    @(negedge clk_i); adapter_rst_i = 0; lvl_we_i = 0;
  endtask

  task automatic end_frame();
    clear_inputs(); frame_end_i = 1;
    @(negedge clk_i); frame_end_i = 0;
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk_i); wd++; end
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=0", wd);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 level after reset", level_o, 0);
    chk("R1 grant after reset", tx_start_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // table walk: R2 sized levels, R3 whole-frame levels, R4 deadlock
    for (int i = 0; i < NV; i++) begin
      logic [2:0] lv; logic [11:0] by; logic ld, wt, st, ex;
      {lv, by, ld, wt, st, ex} = VEC[i];
      set_level(lv);
      chk("R7 write in adapter reset", level_o, lv);
      fifo_bytes_i = by; frame_loaded_i = ld; tx_wait_i = wt; dma_stall_i = st;
      @(negedge clk_i);
      chk(lv > 4 ? "R3 whole-frame grant" : (wt && st ? "R4 deadlock grant" : "R2 threshold grant"),
          tx_start_o, ex);
      end_frame();
    end

    // R9 latch and clear
    set_level(3'd0);
    fifo_bytes_i = 64;
    @(negedge clk_i); chk("R9 grant set", tx_start_o, 1);
    fifo_bytes_i = 0;
    @(negedge clk_i); chk("R9 grant held after drain", tx_start_o, 1);
    frame_end_i = 1;
    @(negedge clk_i); frame_end_i = 0; chk("R9 cleared by frame end", tx_start_o, 0);
    fifo_bytes_i = 64; frame_end_i = 1;
    @(negedge clk_i); frame_end_i = 0; chk("R9 clear beats set", tx_start_o, 0);
    @(negedge clk_i); chk("R9 grant again", tx_start_o, 1);
    fifo_bytes_i = 0; underrun_abort_i = 1;
    @(negedge clk_i); underrun_abort_i = 0;
    chk("R9 cleared by abort", tx_start_o, 0);
    chk("R5 level bumped", level_o, 1);
    underrun_abort_i = 1;
    @(negedge clk_i); underrun_abort_i = 0;
    chk("R5 second bump", level_o, 2);

    // R7 write ignored outside adapter reset
    lvl_we_i = 1; lvl_wdata_i = 3'd6;
    @(negedge clk_i); lvl_we_i = 0;
    chk("R7 write ignored", level_o, 2);

    // R8 write beats abort
    adapter_rst_i = 1; lvl_we_i = 1; lvl_wdata_i = 3'd4; underrun_abort_i = 1;
    @(negedge clk_i); lvl_we_i = 0; underrun_abort_i = 0;
    chk("R8 write priority", level_o, 4);

    // R10 adapter reset blocks grant
    fifo_bytes_i = 12'd4000;
    @(negedge clk_i); chk("R10 grant blocked", tx_start_o, 0);
    @(negedge clk_i); chk("R10 grant still blocked", tx_start_o, 0);
    adapter_rst_i = 0;
    @(negedge clk_i); chk("R10 grant after release", tx_start_o, 1);
    end_frame();

    // R6 saturation
    set_level(3'd6);
    underrun_abort_i = 1;
    @(negedge clk_i); chk("R6 reach 7", level_o, 7);
    @(negedge clk_i); underrun_abort_i = 0;
    chk("R6 saturate at 7", level_o, 7);

    // R1 reset mid-run
    fifo_bytes_i = 0; frame_loaded_i = 1;
    @(negedge clk_i); chk("R3 grant before reset", tx_start_o, 1);
    rst_ni = 0;
    @(negedge clk_i);
    chk("R1 level cleared", level_o, 0);
    chk("R1 grant cleared", tx_start_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule